// File: doc/BRIEF.md
# BCD Clock Calendar Core

This block holds the time of day and the calendar date as eight packed-BCD bytes. They run from hundredths of a second up to a two-digit year. Each cycle in which the 100 Hz tick enable is high advances the hundredths field. Carries ripple upward through seconds, minutes and hours in the same cycle. The day carry then reaches the weekday, date, month and year fields. The date field wraps at the last day of the current month. February has 29 days in any year whose two BCD digits form a multiple of four.

An access sequencer outside this block writes whole bytes through a parallel load port: an enable, a register index and a data byte. The sequencer reads the complete eight-byte image from one wide output. Several control flags share bytes with the time fields:
- a 12/24-hour selector and an AM/PM flag in the hours byte;
- a stop flag for the count in the weekday byte;
- a stored reset-enable flag in the weekday byte.

Every bit position that carries no field always reads as zero.

Top module: `bcd_calendar_core`

## Requirements
- R1: Byte 0 holds hundredths of a second as two BCD digits from 00 to 99. Each counted tick adds one. From 99 it goes to 00 and carries into byte 1. Digit 9 in the low position rolls over into the tens digit.
- R2: Bytes 1 (seconds) and 2 (minutes) count in BCD from 00 to 59. From 59 each goes to 00 and carries into the next byte up.
- R3: With hours bit 7 at 0, the hours byte counts in 24-hour form from 00 to 23. Bits 5:4 hold the tens digit. From 23 the byte goes to 00 and raises the day carry.
- R4: With hours bit 7 at 1, the hours byte is in 12-hour form:
  - bits 4:0 hold the hour from 01 to 12 and bit 5 is the PM flag (1 = PM);
  - from 11 the hour goes to 12 and the PM flag toggles;
  - from 12 the hour goes to 01;
  - the day carry is raised only on the step from 11 PM to 12 AM.
- R5: Byte 4 holds three fields:
  - bits 2:0 are the weekday from 1 to 7, which advances on each day carry and goes from 7 back to 1;
  - bit 5 is the stop flag, where 0 means counting;
  - bit 4 is a reset-enable flag that is stored and read back.
- R6: Byte 5 (date, 01 to 31) steps on the day carry and wraps to 01 after the last day of the month held in byte 6. That last day is 30 for April, June, September and November and 31 for the other months except February. Byte 6 (month, 01 to 12) wraps from 12 to 01 and carries into byte 7 (year, 00 to 99). The year wraps from 99 to 00.
- R7: February ends on the 29th when the year byte, read as a two-digit decimal number, is divisible by 4, year 00 included. In other years it ends on the 28th.
- R8: While byte 4 bit 5 is 1, ticks are ignored and every byte holds its value.
- R9: Bits without a field always read 0, whatever value was loaded. The read masks are:

  | Byte | 1 | 2 | 3 | 4 | 5 | 6 |
  |---|---|---|---|---|---|---|
  | Mask | 7F | 7F | BF | 37 | 3F | 1F |

  Bytes 0 and 7 use every bit.
- R10: A load writes the masked byte into the register selected by its index. It takes effect on the next clock edge even when a tick arrives in the same cycle. A carry into the loaded register in that cycle is dropped, and nothing carries out of that register.
- R11: After reset the image is 00 00 00 00 01 01 01 00 for bytes 0 to 7. This is midnight in 24-hour mode, weekday 1, counting enabled, 1 January of year 00.
- R12: Byte k of the image appears on rd_image bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one pulse per hundredth of a second |
| ld_en | input | 1 | Load strobe for one byte |
| ld_sel | input | 3 | Index of the register to load (0 to 7) |
| ld_byte | input | 8 | Byte value to load |
| rd_image | output | 64 | All eight registers, byte k at bits 8k+7:8k |

## Verification
At 100 ticks per second, the year, month and noon/midnight rollovers lie months of simulated time away from reset. The bench therefore loads all eight bytes to a value one tick before each boundary and then applies a single tick. The hardest case is a load that lands in the same cycle as a rippling carry. It is reached by holding hundredths at 99 and pulsing the tick and the load together. A behavioural model runs beside the design and is compared on every cycle, so every loaded value and every tick is checked.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int REG_W = 8;
    localparam int REG_N = 8;
    localparam int SEL_W = $clog2(REG_N);

    // Bits that carry a field, per register index.
    function automatic logic [7:0] reg_mask(input int idx);
        case (idx)
            1, 2:    return 8'h7F;
            3:       return 8'hBF;
            4:       return 8'h37;
            5:       return 8'h3F;
            6:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic is_leap(input logic [7:0] yr);
        logic [6:0] b;
        b = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
        return (b % 7'd4) == 7'd0;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field
    import cal_pkg::*;
#(
    parameter int           W   = 8,
    parameter logic [W-1:0] LO  = '0,
    parameter logic [W-1:0] HI  = W'(8'h59),
    parameter logic [W-1:0] RST = LO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] value,
    output logic         carry
);
    logic at_top;

    assign at_top = (value >= HI);
    assign carry  = inc & ~ld & at_top;

    always_ff @(posedge clk) begin
        if (!rst_n)   value <= RST;
        else if (ld)  value <= ld_val;
        else if (inc) value <= at_top ? LO : W'(bcd_inc(8'(value)));
    end

    AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (value == LO)); // R2
endmodule

// File: rtl/cal_hour_field.sv
module cal_hour_field
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    output logic [7:0] value,
    output logic       carry
);
    logic [7:0] h12, h24, hr_nxt;
    logic       day_wrap;

    always_comb begin
        h12      = {3'b000, value[4:0]};
        h24      = {2'b00, value[5:0]};
        hr_nxt   = value;
        day_wrap = 1'b0;
        if (value[7]) begin
            if (h12 == 8'h12) begin
                hr_nxt = {value[7:5], 5'h01};
            end else if (h12 == 8'h11) begin
                hr_nxt   = {2'b10, ~value[5], 5'h12};
                day_wrap = value[5];
            end else begin
                hr_nxt = {value[7:5], 5'b0} | (bcd_inc(h12) & 8'h1F);
            end
        end else begin
            if (h24 >= 8'h23) begin
                hr_nxt   = 8'h00;
                day_wrap = 1'b1;
            end else begin
                hr_nxt = bcd_inc(h24) & 8'h3F;
            end
        end
    end

    assign carry = inc & ~ld & day_wrap;

    always_ff @(posedge clk) begin
        if (!rst_n)   value <= 8'h00;
        else if (ld)  value <= ld_val;
        else if (inc) value <= hr_nxt;
    end

    AST_HR12_MERIDIEM: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && value[7] && value[4:0] == 5'h11) |=> (value[5] != $past(value[5]))); // R4
    AST_HR12_NOON_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && value[7] && value[4:0] == 5'h12) |=> (value[4:0] == 5'h01 && $stable(value[5]))); // R4
    AST_HR24_MIDNIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !value[7]) |=> (value == 8'h00)); // R3
endmodule

// File: rtl/cal_date_field.sv
module cal_date_field
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] value,
    output logic       carry
);
    logic [7:0] last;
    logic       at_end;

    assign last   = last_day(month, is_leap(year));
    assign at_end = (value >= last);
    assign carry  = inc & ~ld & at_end;

    always_ff @(posedge clk) begin
        if (!rst_n)   value <= 8'h01;
        else if (ld)  value <= ld_val;
        else if (inc) value <= at_end ? 8'h01 : bcd_inc(value);
    end

    AST_DATE_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (value == 8'h01)); // R6
    AST_FEB_LEAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && month == 8'h02 && value == 8'h28 && is_leap(year)) |=> (value == 8'h29)); // R7
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
    import cal_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   ld_en,
    input  logic [SEL_W-1:0]       ld_sel,
    input  logic [REG_W-1:0]       ld_byte,
    output logic [REG_N*REG_W-1:0] rd_image
);
    localparam int CHAIN_N = 3;

    logic [REG_N-1:0] hit;
    logic [7:0]       ld_val [REG_N];
    logic [7:0]       img    [REG_N];
    logic [CHAIN_N:0] chain_c;
    logic [1:0]       ctrl_q;
    logic [2:0]       dow_val;
    logic             osc_stop, day_c, dow_wrap, date_c, mon_c, yr_wrap;

    genvar k;
    generate
        for (k = 0; k < REG_N; k++) begin : g_ld
            assign hit[k]    = ld_en && (ld_sel == SEL_W'(k));
            assign ld_val[k] = ld_byte & reg_mask(k);
            assign rd_image[k*REG_W +: REG_W] = img[k];

            AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
                (img[k] & ~reg_mask(k)) == 8'h00); // R9
            AST_LOAD_OVERRIDES: assert property (@(posedge clk) disable iff (!rst_n)
                hit[k] |=> (img[k] == $past(ld_val[k]))); // R10
        end
    endgenerate

    assign osc_stop   = ctrl_q[1];
    assign chain_c[0] = tick_en & ~osc_stop;

    // hundredths, seconds, minutes: one ripple stage each
    generate
        for (k = 0; k < CHAIN_N; k++) begin : g_chain
            cal_bcd_field #(
                .W  (8),
                .LO (8'h00),
                .HI ((k == 0) ? 8'h99 : 8'h59),
                .RST(8'h00)
            ) u_fld (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (chain_c[k]),
                .ld    (hit[k]),
                .ld_val(ld_val[k]),
                .value (img[k]),
                .carry (chain_c[k+1])
            );
        end
    endgenerate

    cal_hour_field u_hour (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (chain_c[CHAIN_N]),
        .ld    (hit[3]),
        .ld_val(ld_val[3]),
        .value (img[3]),
        .carry (day_c)
    );

    cal_bcd_field #(.W(3), .LO(3'd1), .HI(3'd7), .RST(3'd1)) u_dow (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (day_c),
        .ld    (hit[4]),
        .ld_val(ld_val[4][2:0]),
        .value (dow_val),
        .carry (dow_wrap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= 2'b00;
        else if (hit[4]) ctrl_q <= ld_val[4][5:4];
    end

    assign img[4] = {2'b00, ctrl_q, 1'b0, dow_val};

    cal_date_field u_date (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (day_c),
        .ld    (hit[5]),
        .ld_val(ld_val[5]),
        .month (img[6]),
        .year  (img[7]),
        .value (img[5]),
        .carry (date_c)
    );

    cal_bcd_field #(.W(8), .LO(8'h01), .HI(8'h12), .RST(8'h01)) u_month (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (date_c),
        .ld    (hit[6]),
        .ld_val(ld_val[6]),
        .value (img[6]),
        .carry (mon_c)
    );

    cal_bcd_field #(.W(8), .LO(8'h00), .HI(8'h99), .RST(8'h00)) u_year (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mon_c),
        .ld    (hit[7]),
        .ld_val(ld_val[7]),
        .value (img[7]),
        .carry (yr_wrap)
    );

    AST_OSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_stop && !ld_en) |=> $stable(rd_image)); // R8
    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        dow_wrap |=> (img[4][2:0] == 3'd1)); // R5
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        yr_wrap |=> (img[7] == 8'h00)); // R6
endmodule

// File: tb/bcd_calendar_core_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        ld_en = 1'b0;
    logic [2:0]  ld_sel = 3'd0;
    logic [7:0]  ld_byte = 8'h00;
    logic [63:0] rd_image;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // behavioural reference state
    int m_hs, m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
    bit m_m12, m_pm, m_rst, m_osc;

    always #2 clk = ~clk;

    bcd_calendar_core dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_byte (ld_byte),
        .rd_image(rd_image)
    );

    function automatic logic [7:0] bcd(int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int dec(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] mask_of(int k);
        case (k)
            1, 2:    return 8'h7F;
            3:       return 8'hBF;
            4:       return 8'h37;
            5:       return 8'h3F;
            6:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic int days_in(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mdl_byte(int k);
        case (k)
            0: return bcd(m_hs);
            1: return bcd(m_sec);
            2: return bcd(m_min);
            3: return m_m12 ? (8'h80 | (m_pm ? 8'h20 : 8'h00) | bcd(m_hr)) : bcd(m_hr);
            4: return {2'b00, m_osc, m_rst, 1'b0, 3'(m_dow)};
            5: return bcd(m_date);
            6: return bcd(m_mon);
            default: return bcd(m_yr);
        endcase
    endfunction

    function automatic string tag_of(int k);
        case (k)
            0: return "R1";
            1, 2: return "R2";
            3: return "R3";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic void model_reset();
        m_hs = 0; m_sec = 0; m_min = 0; m_hr = 0; m_m12 = 0; m_pm = 0;
        m_dow = 1; m_rst = 0; m_osc = 0; m_date = 1; m_mon = 1; m_yr = 0;
    endfunction

    function automatic void model_step(bit tk, bit le, int sel, logic [7:0] b);
        bit c;
        logic [7:0] mb;
        c = tk && !m_osc;
        if (le && sel == 0) c = 0;
        else if (c) begin m_hs++; if (m_hs == 100) m_hs = 0; else c = 0; end
        if (le && sel == 1) c = 0;
        else if (c) begin m_sec++; if (m_sec == 60) m_sec = 0; else c = 0; end
        if (le && sel == 2) c = 0;
        else if (c) begin m_min++; if (m_min == 60) m_min = 0; else c = 0; end
        if (le && sel == 3) c = 0;
        else if (c) begin
            if (m_m12) begin
                if (m_hr == 12) begin m_hr = 1; c = 0; end
                else if (m_hr == 11) begin m_hr = 12; c = m_pm; m_pm = !m_pm; end
                else begin m_hr++; c = 0; end
            end else begin
                m_hr++;
                if (m_hr == 24) m_hr = 0; else c = 0;
            end
        end
        if (!(le && sel == 4) && c) m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        if (le && sel == 5) c = 0;
        else if (c) begin
            if (m_date >= days_in(m_mon, m_yr)) m_date = 1;
            else begin m_date++; c = 0; end
        end
        if (le && sel == 6) c = 0;
        else if (c) begin if (m_mon == 12) m_mon = 1; else begin m_mon++; c = 0; end end
        if (!(le && sel == 7) && c) m_yr = (m_yr + 1) % 100;
        if (le) begin
            mb = b & mask_of(sel);
            case (sel)
                0: m_hs = dec(mb);
                1: m_sec = dec(mb);
                2: m_min = dec(mb);
                3: begin
                    m_m12 = mb[7];
                    if (m_m12) begin m_pm = mb[5]; m_hr = dec(mb & 8'h1F); end
                    else begin m_pm = 0; m_hr = dec(mb & 8'h3F); end
                end
                4: begin m_dow = int'(mb[2:0]); m_rst = mb[4]; m_osc = mb[5]; end
                5: m_date = dec(mb);
                6: m_mon = dec(mb);
                default: m_yr = dec(mb);
            endcase
        end
    endfunction

    task automatic cmp_all();
        for (int k = 0; k < 8; k++) begin
            checks++;
            if (rd_image[k*8 +: 8] !== mdl_byte(k)) begin
                errors++;
                $display("FAIL %s model compare byte %0d: got %02h expected %02h",
                         tag_of(k), k, rd_image[k*8 +: 8], mdl_byte(k));
            end
        end
    endtask

    task automatic chk(int k, logic [7:0] exp, string tag);
        checks++;
        if (rd_image[k*8 +: 8] !== exp) begin
            errors++;
            $display("FAIL %s byte %0d: got %02h expected %02h", tag, k, rd_image[k*8 +: 8], exp);
        end
    endtask

    task automatic step(bit tk, bit le, int sel, logic [7:0] b);
        tick_en = tk;
        ld_en   = le;
        ld_sel  = 3'(sel);
        ld_byte = b;
        model_step(tk, le, sel, b);
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        ld_en   = 1'b0;
        cmp_all();
    endtask

    task automatic set_regs(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3,
                            logic [7:0] b4, logic [7:0] b5, logic [7:0] b6, logic [7:0] b7);
        step(0, 1, 0, b0); step(0, 1, 1, b1); step(0, 1, 2, b2); step(0, 1, 3, b3);
        step(0, 1, 4, b4); step(0, 1, 5, b5); step(0, 1, 6, b6); step(0, 1, 7, b7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset image
        chk(0, 8'h00, "R11"); chk(1, 8'h00, "R11"); chk(2, 8'h00, "R11"); chk(3, 8'h00, "R11");
        chk(4, 8'h01, "R11"); chk(5, 8'h01, "R11"); chk(6, 8'h01, "R11"); chk(7, 8'h00, "R11");
        cmp_all();

        // R1 hundredths count and carry
        for (int n = 0; n < 100; n++) step(1, 0, 0, 8'h00);
        chk(0, 8'h00, "R1"); chk(1, 8'h01, "R1");
        for (int n = 0; n < 23; n++) step(1, 0, 0, 8'h00);
        chk(0, 8'h23, "R1");

        // R2 seconds digit and minute carry
        set_regs(8'h99, 8'h09, 8'h41, 8'h05, 8'h01, 8'h10, 8'h03, 8'h21);
        step(1, 0, 0, 8'h00);
        chk(1, 8'h10, "R2");
        set_regs(8'h99, 8'h59, 8'h41, 8'h05, 8'h01, 8'h10, 8'h03, 8'h21);
        step(1, 0, 0, 8'h00);
        chk(1, 8'h00, "R2"); chk(2, 8'h42, "R2"); chk(3, 8'h05, "R2");

        // R3 24-hour tens digit and full wrap, R5 weekday, R6 year wrap
        set_regs(8'h99, 8'h59, 8'h59, 8'h19, 8'h02, 8'h10, 8'h03, 8'h21);
        step(1, 0, 0, 8'h00);
        chk(3, 8'h20, "R3");
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        step(1, 0, 0, 8'h00);
        chk(3, 8'h00, "R3"); chk(4, 8'h01, "R5"); chk(5, 8'h01, "R6");
        chk(6, 8'h01, "R6"); chk(7, 8'h00, "R6");

        // R4 12-hour mode
        set_regs(8'h99, 8'h59, 8'h59, 8'h91, 8'h03, 8'h15, 8'h06, 8'h24);
        step(1, 0, 0, 8'h00);
        chk(3, 8'hB2, "R4"); chk(5, 8'h15, "R4");
        step(0, 1, 0, 8'h99); step(0, 1, 1, 8'h59); step(0, 1, 2, 8'h59);
        step(1, 0, 0, 8'h00);
        chk(3, 8'hA1, "R4");
        set_regs(8'h99, 8'h59, 8'h59, 8'hB1, 8'h03, 8'h15, 8'h06, 8'h24);
        step(1, 0, 0, 8'h00);
        chk(3, 8'h92, "R4"); chk(5, 8'h16, "R4"); chk(4, 8'h04, "R5");

        // R6 month lengths
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h01, "R6"); chk(6, 8'h05, "R6");
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h21);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h01, "R6"); chk(6, 8'h02, "R6");
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h21);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h31, "R6");

        // R7 leap years
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h01, "R7"); chk(6, 8'h03, "R7");
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h29, "R7");
        step(0, 1, 0, 8'h99); step(0, 1, 1, 8'h59); step(0, 1, 2, 8'h59); step(0, 1, 3, 8'h23);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h01, "R7"); chk(6, 8'h03, "R7");
        set_regs(8'h99, 8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        step(1, 0, 0, 8'h00);
        chk(5, 8'h29, "R7");

        // R8 stopped count ignores ticks
        set_regs(8'h37, 8'h12, 8'h34, 8'h08, 8'h21, 8'h05, 8'h07, 8'h44);
        for (int n = 0; n < 50; n++) step(1, 0, 0, 8'h00);
        chk(0, 8'h37, "R8"); chk(1, 8'h12, "R8"); chk(4, 8'h21, "R8");
        step(0, 1, 4, 8'h01);
        step(1, 0, 0, 8'h00);
        chk(0, 8'h38, "R8");

        // R5 reset-enable flag stored
        step(0, 1, 4, 8'h11);
        chk(4, 8'h11, "R5");
        step(0, 1, 4, 8'h01);

        // R10 load in the same cycle as a carry
        step(0, 1, 0, 8'h99); step(0, 1, 1, 8'h20); step(0, 1, 2, 8'h15);
        step(1, 1, 1, 8'h30);
        chk(0, 8'h00, "R10"); chk(1, 8'h30, "R10"); chk(2, 8'h15, "R10");
        step(1, 1, 0, 8'h42);
        chk(0, 8'h42, "R10"); chk(1, 8'h30, "R10");

        // R9 zero bits
        step(0, 1, 1, 8'hC5); chk(1, 8'h45, "R9");
        step(0, 1, 2, 8'hB7); chk(2, 8'h37, "R9");
        step(0, 1, 3, 8'h55); chk(3, 8'h15, "R9");
        step(0, 1, 3, 8'hD2); chk(3, 8'h92, "R9");
        step(0, 1, 4, 8'hCA); chk(4, 8'h02, "R9");
        step(0, 1, 5, 8'hD9); chk(5, 8'h19, "R9");
        step(0, 1, 6, 8'hE9); chk(6, 8'h09, "R9");

        // R12 byte placement on the wide port
        step(0, 1, 7, 8'h42);
        checks++;
        if (rd_image[63:56] !== 8'h42 || rd_image[7:0] !== 8'h42) begin
            errors++;
            $display("FAIL R12 placement: got %02h/%02h expected 42/42", rd_image[63:56], rd_image[7:0]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule